// File: doc/BRIEF.md
# Biphase-Mark Frame Encoder for Four Serial Audio Streams

The block turns four parallel serial audio streams and three slow control bits into one self-clocking serial line. Every sample period it sends a frame of 36 cycles. In each cycle, the block takes one bit from each of the four streams, which forms a 4-bit nibble, and sends the nibble as eight chips. Each data bit is sent as a biphase-mark (FM) cell of two chips. A transition always marks the start of a cell, and a second transition in the middle of the cell marks a 1.

Two cycles carry special content:

- In cycle 18, the two switch bits and a one-bit volume sample replace three of the stream bits.
- In cycle 35, the block sends the XOR parity of all nibbles sent in cycles 1 to 34.

Cycle 36 is a fixed sync pattern. This pattern breaks the FM rule on purpose and has no DC content, so a receiver can find frame boundaries in it.

The rising edge of the frame strobe aligns the frame. The block runs on the chip clock and sends one chip per clock. A frame therefore lasts 288 clocks.

Top module: `fm_frame_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, `line_out` goes low and the position returns to cycle 1, chip 0. The first clock after reset is released sends chip 0 of cycle 1.
- R2: A frame is 36 cycles of 8 chips (288 clocks). After chip 7 of cycle 36, the position wraps to cycle 1, chip 0 without any strobe. In a data cycle, `adc_bits` is sampled only at chip 0. Bit j of the nibble (j = 0 first, sent in chips 2j and 2j+1) comes from `adc_bits[j]`. The value of `adc_bits` at other chips has no effect.
- R3: Each data bit toggles `line_out` at its first chip. A bit of value 1 toggles the line again at its second chip. A bit of value 0 holds the line at its second chip.
- R4: Cycle 36 toggles `line_out` only at chips 0 and 4 and holds the line at the other six chips.
- R5: The cycle 18 nibble is built as follows: bit 0 is `sw_in[0]`, bit 1 is `sw_in[1]`, bit 2 is `vol_in`, and bit 3 is `adc_bits[3]` sampled at chip 0 of cycle 18.
- R6: The cycle 35 nibble is the XOR of the nibbles actually sent in cycles 1 to 34 of the same frame, including the substituted cycle 18 nibble.
- R7: `sw_in` and `vol_in` are sampled only at the clock that sends chip 0 of cycle 1. Changes at any other time do not affect the frame in progress.
- R8: If `lrck` is high at a clock and was low at the previous clock, that clock sends chip 0 of cycle 1, wherever the frame was.
- R9: The level of `line_out` carries across frame boundaries. Only a reset sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock, one chip per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lrck | input | 1 | Frame strobe; a rising edge starts a frame |
| adc_bits | input | 4 | One bit from each of the four serial streams |
| sw_in | input | 2 | Two switch bits, carried in cycle 18 |
| vol_in | input | 1 | One-bit volume sample, carried in cycle 18 |
| line_out | output | 1 | Biphase-mark encoded chip line |

## Verification
A wrong position counter shows up on `line_out` within one cycle. It either drops a toggle at a bit start or puts the sync gap into the wrong cycle. Both errors are visible in the next few chips, not only at the frame end.

A corrupted parity register or a stale control sample stays hidden until cycle 35 or cycle 18 of the frame. Because of this, the bench changes the controls and the stream bits at chips where they must be ignored.

A lost line level would cause every following chip of every later frame to mismatch. For this reason, the output is compared against the model on every clock.

// File: rtl/fm_frame_pkg.sv
package fm_frame_pkg;
    localparam int STREAMS       = 4;
    localparam int CHIPS_PER_BIT = 2;
    localparam int CHIPS_PER_CYC = STREAMS * CHIPS_PER_BIT;
    localparam int CYCLES        = 36;
    localparam int CTL_CYCLE     = 18;
    localparam int PAR_CYCLE     = CYCLES - 1;
    localparam int CYC_W         = $clog2(CYCLES + 1);
    localparam int CHIP_W        = $clog2(CHIPS_PER_CYC);

    localparam logic [CYC_W-1:0]  CYC_FIRST = CYC_W'(1);
    localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(CYCLES);
    localparam logic [CYC_W-1:0]  CYC_CTL   = CYC_W'(CTL_CYCLE);
    localparam logic [CYC_W-1:0]  CYC_PAR   = CYC_W'(PAR_CYCLE);
    localparam logic [CHIP_W-1:0] CHIP_LAST = CHIP_W'(CHIPS_PER_CYC - 1);
    localparam logic [CHIP_W-1:0] CHIP_HALF = CHIP_W'(CHIPS_PER_CYC / 2);

    typedef logic [STREAMS-1:0] nib_t;

    typedef struct packed {
        logic [CYC_W-1:0]  cyc;
        logic [CHIP_W-1:0] chip;
    } pos_t;

    typedef struct packed {
        logic vol;
        logic sw_b;
        logic sw_a;
    } ctl_t;

    typedef enum logic [1:0] {
        K_DATA,
        K_CTRL,
        K_PAR,
        K_SYNC
    } kind_e;

    localparam pos_t POS_START = '{cyc: CYC_FIRST, chip: '0};

    function automatic kind_e kind_of(input logic [CYC_W-1:0] c);
        if (c == CYC_CTL)       return K_CTRL;
        else if (c == CYC_PAR)  return K_PAR;
        else if (c == CYC_LAST) return K_SYNC;
        else                    return K_DATA;
    endfunction

    function automatic pos_t pos_advance(input pos_t p);
        pos_t n;
        if (p.chip == CHIP_LAST) begin
            n.chip = '0;
            n.cyc  = (p.cyc == CYC_LAST) ? CYC_FIRST : p.cyc + CYC_W'(1);
        end else begin
            n.chip = p.chip + CHIP_W'(1);
            n.cyc  = p.cyc;
        end
        return n;
    endfunction

    function automatic logic sync_toggle(input logic [CHIP_W-1:0] ch);
        return (ch == '0) || (ch == CHIP_HALF);
    endfunction
endpackage

// File: rtl/fm_frame_seq.sv
module fm_frame_seq
    import fm_frame_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lrck,
    output pos_t pos,
    output pos_t pos_q,
    output logic strobe_edge,
    output logic frame_start
);
    logic lrck_q;

    assign strobe_edge = lrck & ~lrck_q;
    assign pos         = strobe_edge ? POS_START : pos_q;
    assign frame_start = (pos.cyc == CYC_FIRST) && (pos.chip == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lrck_q <= 1'b1;
            pos_q  <= POS_START;
        end else begin
            lrck_q <= lrck;
            pos_q  <= pos_advance(pos);
        end
    end
endmodule

// File: rtl/fm_nibble_src.sv
module fm_nibble_src
    import fm_frame_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pos_t  pos,
    input  logic  frame_start,
    input  nib_t  adc_bits,
    input  ctl_t  ctl_in,
    output kind_e kind,
    output nib_t  cur_nib
);
    nib_t nib_q;
    nib_t par_q;
    ctl_t ctl_q;
    nib_t fresh;

    assign kind = kind_of(pos.cyc);

    always_comb begin
        fresh = adc_bits;
        unique case (kind)
            K_CTRL: begin
                fresh[0] = ctl_q.sw_a;
                fresh[1] = ctl_q.sw_b;
                fresh[2] = ctl_q.vol;
            end
            K_PAR:   fresh = par_q;
            K_SYNC:  fresh = '0;
            default: fresh = adc_bits;
        endcase
    end

    assign cur_nib = (pos.chip == '0) ? fresh : nib_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nib_q <= '0;
            par_q <= '0;
            ctl_q <= '0;
        end else begin
            if (frame_start)
                ctl_q <= ctl_in;
            if (pos.chip == '0) begin
                nib_q <= fresh;
                if (pos.cyc < CYC_PAR)
                    par_q <= (frame_start ? '0 : par_q) ^ fresh;
            end
        end
    end
endmodule

// File: rtl/fm_line_drv.sv
module fm_line_drv
    import fm_frame_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pos_t  pos,
    input  kind_e kind,
    input  nib_t  cur_nib,
    output logic  line_out
);
    logic line_q;
    logic toggle;
    logic mid_cell;

    assign mid_cell = pos.chip[0];

    always_comb begin
        if (kind == K_SYNC)
            toggle = sync_toggle(pos.chip);
        else
            toggle = ~mid_cell | cur_nib[pos.chip[CHIP_W-1:1]];
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= 1'b0;
        else     line_q <= line_q ^ toggle;
    end

    assign line_out = line_q;
endmodule

// File: rtl/fm_frame_encoder.sv
module fm_frame_encoder
    import fm_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lrck,
    input  logic [STREAMS-1:0] adc_bits,
    input  logic [1:0]        sw_in,
    input  logic              vol_in,
    output logic              line_out
);
    pos_t  pos;
    pos_t  pos_q;
    logic  strobe_edge;
    logic  frame_start;
    kind_e kind;
    nib_t  cur_nib;
    ctl_t  ctl_in;

    assign ctl_in = '{vol: vol_in, sw_b: sw_in[1], sw_a: sw_in[0]};

    fm_frame_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .lrck        (lrck),
        .pos         (pos),
        .pos_q       (pos_q),
        .strobe_edge (strobe_edge),
        .frame_start (frame_start)
    );

    fm_nibble_src u_src (
        .clk         (clk),
        .rst         (rst),
        .pos         (pos),
        .frame_start (frame_start),
        .adc_bits    (adc_bits),
        .ctl_in      (ctl_in),
        .kind        (kind),
        .cur_nib     (cur_nib)
    );

    fm_line_drv u_line (
        .clk      (clk),
        .rst      (rst),
        .pos      (pos),
        .kind     (kind),
        .cur_nib  (cur_nib),
        .line_out (line_out)
    );
endmodule

// File: rtl/fm_frame_encoder_chk.sv
module fm_frame_encoder_chk
    import fm_frame_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  line_out,
    input pos_t  pos,
    input pos_t  pos_q,
    input logic  strobe_edge,
    input kind_e kind
);
    // R1: reset drives the line low and rewinds the position
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!line_out && pos_q == POS_START));

    // R3: every bit cell outside the sync cycle opens with a toggle
    a_r3_cell_edge: assert property (@(posedge clk) disable iff (rst)
        (kind != K_SYNC && !pos.chip[0]) |=> (line_out != $past(line_out)));

    // R4: the sync cycle leaves out the toggle at chips 2 and 6
    a_r4_sync_gap: assert property (@(posedge clk) disable iff (rst)
        (kind == K_SYNC && pos.chip[0] == 1'b0 && pos.chip != '0 && pos.chip != CHIP_HALF)
        |=> $stable(line_out));

    // R2: the last chip of the frame wraps to the first
    a_r2_frame_wrap: assert property (@(posedge clk) disable iff (rst)
        (pos.cyc == CYC_LAST && pos.chip == CHIP_LAST) |=> (pos_q == POS_START || strobe_edge));

    // R8: a strobe edge makes the next position chip 1 of cycle 1
    a_r8_realign: assert property (@(posedge clk) disable iff (rst)
        strobe_edge |=> (pos_q.cyc == CYC_FIRST && pos_q.chip == CHIP_W'(1)));
endmodule

bind fm_frame_encoder fm_frame_encoder_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .line_out    (line_out),
    .pos         (pos),
    .pos_q       (pos_q),
    .strobe_edge (strobe_edge),
    .kind        (kind)
);

// File: tb/test_fm_frame_encoder.sv
module test_fm_frame_encoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lrck = 1'b0;
    logic [3:0] adc_bits = 4'h0;
    logic [1:0] sw_in = 2'b00;
    logic       vol_in = 1'b0;
    logic       line_out;

    int   checks = 0;
    int   errors = 0;
    logic exp_lvl = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    fm_frame_encoder i_fm_frame_encoder (
        .clk      (clk),
        .rst      (rst),
        .lrck     (lrck),
        .adc_bits (adc_bits),
        .sw_in    (sw_in),
        .vol_in   (vol_in),
        .line_out (line_out)
    );

    task automatic check(input logic got, input logic want, input string tag, input int idx);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s chip %0d: line_out=%b expected %b", tag, idx, got, want);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; lrck = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        exp_lvl = 1'b0;
        check(line_out, 1'b0, "R1 reset level", -1);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One frame (or its first n_chips chips), built from the requirements
    task automatic run_frame(input bit use_lrck, input int n_chips,
                             input logic [1:0] sw, input logic vol,
                             input bit realign, input bit after_reset);
        logic [3:0] raw  [1:36];
        logic [3:0] sent [1:36];
        logic [3:0] par;
        par = 4'h0;
        for (int c = 1; c <= 36; c++) raw[c] = 4'($urandom);
        for (int c = 1; c <= 36; c++) begin
            if (c == 18)      sent[c] = {raw[c][3], vol, sw[1], sw[0]};   // R5
            else if (c == 35) sent[c] = par;                              // R6
            else              sent[c] = raw[c];
            if (c <= 34) par = par ^ sent[c];
        end
        for (int idx = 0; idx < n_chips; idx++) begin
            int   c;
            int   k;
            logic tg;
            string tag;
            c = idx / 8 + 1;
            k = idx % 8;
            if (idx != 0) @(negedge clk);
            adc_bits = (k == 0) ? raw[c] : ~raw[c];          // R2: other chips ignored
            lrck     = use_lrck && (idx < 144);
            sw_in    = (idx == 0) ? sw  : ~sw;                // R7
            vol_in   = (idx == 0) ? vol : ~vol;
            if (c == 36) tg = (k == 0) || (k == 4);
            else         tg = (k % 2 == 0) ? 1'b1 : sent[c][k / 2];
            exp_lvl = exp_lvl ^ tg;
            if (c == 36)                  tag = "R4 sync";
            else if (c == 35)             tag = "R6 parity";
            else if (c == 18)             tag = "R5 R7 control";
            else if (c == 1 && realign)   tag = "R8 realign";
            else if (c == 1 && after_reset) tag = "R1 restart";
            else if (c == 1)              tag = "R9 carry";
            else                          tag = "R2 R3 data";
            @(posedge clk);
            #1;
            check(line_out, exp_lvl, tag, idx);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        do_reset();
        // do_reset leaves us at a negedge; run_frame drives its first chip there
        run_frame(1'b1, 288, 2'b01, 1'b1, 1'b0, 1'b1);
        run_frame(1'b1, 288, 2'b10, 1'b0, 1'b0, 1'b0);
        run_frame(1'b0, 288, 2'b11, 1'b1, 1'b0, 1'b0);   // free-running wrap, R2
        run_frame(1'b0, 100, 2'b00, 1'b0, 1'b0, 1'b0);   // cut short
        run_frame(1'b1, 288, 2'b00, 1'b1, 1'b1, 1'b0);   // strobe mid-frame, R8
        run_frame(1'b0, 288, 2'b10, 1'b1, 1'b0, 1'b0);
        do_reset();
        run_frame(1'b0, 288, 2'b01, 1'b0, 1'b0, 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule